// File: doc/BRIEF.md
# Hardware Run-Time Task Scheduler

This block sequences one iteration of a fixed task graph whose nodes are a mix of hardware tasks and software tasks. Hardware tasks get a one-cycle start strobe and report back on their own done line. Software tasks all share a single CPU. The scheduler hands them out one at a time by raising an interrupt request together with a binary task index, and that task then runs to completion. Every done line comes back to this block, and only this block chooses the run-time order of the software tasks.

Precedence between tasks is set by three parameter masks. One holds edges that always apply. The other two hold edges that apply only when the iteration's conditional bit is 1, or only when it is 0. A single graph can therefore impose a different order on each path. When more than one software task is ready at once, a static rank table decides which one is dispatched first. An iteration starts on a `go` strobe and ends when every task named in the sink mask has finished.

Top module: `tsch_top`

## Requirements
- R1: After a reset with `rst_n` low, `busy`, `complete`, `err`, `sw_irq` and every bit of `hw_start` read 0.
- R2: A `go` pulse that arrives while no iteration is running sets `busy` in the following cycle and captures `cond_in`. A `go` pulse during a running iteration is ignored, and so is any change of `cond_in`.
- R3: A hardware task whose enabled predecessors have all finished gets its `hw_start` bit (bit i is task i) high for exactly one cycle, one cycle after that condition holds. A task with no enabled predecessor is started in the cycle after `busy` rises.
- R4: An edge from the conditional masks applies only when the captured bit equals the edge's label. In the default graph, cond=1 gives software order 0,4,2 and cond=0 gives order 0,2,4.
- R5: Each task is started exactly once per iteration.
- R6: At most one software task is outstanding at a time. `sw_irq` stays high with a stable `sw_idx` (binary task number) until done bit `sw_idx` is seen. It is then low for at least one cycle before the next dispatch.
- R7: Among ready software tasks, the one with the lowest rank in `SW_RANK` is dispatched first, and a tie goes to the lower index.
- R8: When every task in `SINK_PRED` has finished, `complete` rises and `busy` falls. `complete` stays high until the next accepted `go`.
- R9: A done bit for a task that has no start outstanding is ignored, and it sets a sticky `err` that is cleared only by the next accepted `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Starts an iteration (source node) |
| cond_in | input | 1 | Path conditional, captured at an accepted `go` |
| done_in | input | N_TASK | Done bit per task, bit i is task i |
| hw_start | output | N_TASK | One-cycle start strobe per hardware task |
| sw_irq | output | 1 | Interrupt request to the CPU for a software task |
| sw_idx | output | $clog2(N_TASK) | Binary index of the dispatched software task |
| busy | output | 1 | Iteration in progress |
| complete | output | 1 | All sink predecessors finished |
| err | output | 1 | Sticky flag for a done bit with no start outstanding |

## Verification
Suppose the started or finished record is wrong. The port-level sign of that is a task that starts twice, starts too early or never starts. A bench that counts strobes per task sees this within one task latency of the fault, and the missing case shows up as `complete` failing to rise. If the captured conditional is corrupted, the scheduler applies the edges of the other path. The software order then changes at the very next dispatch after the first software task finishes. A faulty dispatch register shows as an index that changes while `sw_irq` is high, or as no gap between two requests, and it is visible in the cycle it happens.

// File: rtl/tsch_pkg.sv
// Shared types for the task scheduler.
// Assumes: included in compile order ahead of every tsch_* module.
package tsch_pkg;

    // Phase of one graph iteration.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } tsch_phase_e;

endpackage

// File: rtl/tsch_iter.sv
// Iteration bookkeeping: the phase, the captured conditional, and which tasks
// have been started and have finished.
// Assumes: launch is non-zero only while run is high, and done_in is a
// single-cycle pulse for each task.
module tsch_iter
    import tsch_pkg::*;
#(
    parameter int                N_TASK    = 6,
    parameter logic [N_TASK-1:0] SINK_PRED = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              cond_in,
    input  logic [N_TASK-1:0] launch,
    input  logic [N_TASK-1:0] done_in,
    output logic              run,
    output logic              cond_q,
    output logic [N_TASK-1:0] started_q,
    output logic [N_TASK-1:0] finished_q,
    output logic              complete,
    output logic              err
);

    tsch_phase_e       phase_q;
    logic              go_acc;
    logic [N_TASK-1:0] outstanding;
    logic [N_TASK-1:0] accept;
    logic              stray;
    logic              sink_met;

    // Decode: accepted go, accepted done bits, stray done bits, sink condition.
    always_comb begin
        go_acc      = go && (phase_q != PH_RUN);
        outstanding = started_q & ~finished_q;
        accept      = done_in & outstanding;
        stray       = |(done_in & ~outstanding);
        sink_met    = (finished_q & SINK_PRED) == SINK_PRED;
    end

    // Phase, conditional capture, start/finish records and the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            cond_q     <= 1'b0;
            started_q  <= '0;
            finished_q <= '0;
            err        <= 1'b0;
        end else if (go_acc) begin
            phase_q    <= PH_RUN;
            cond_q     <= cond_in;
            started_q  <= '0;
            finished_q <= '0;
            err        <= 1'b0;
        end else begin
            started_q  <= started_q | launch;
            finished_q <= finished_q | accept;
            err        <= err | stray;
            if (phase_q == PH_RUN && sink_met) begin
                phase_q <= PH_DONE;
            end
        end
    end

    assign run      = (phase_q == PH_RUN);
    assign complete = (phase_q == PH_DONE);

    // R5: a task that has already been started is never launched again.
    a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (launch & started_q) == '0);

    // R2: the captured conditional does not change during an iteration.
    a_r2_cond_held: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RUN) |=> $stable(cond_q));

    // R8: the done phase is only reached once every sink predecessor has finished.
    a_r8_sink_done: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DONE) |-> sink_met);

    // R9: a stray done bit raises err in the next cycle unless go is accepted.
    a_r9_stray_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (stray && !go_acc) |=> err);

endmodule

// File: rtl/tsch_ready.sv
// Readiness evaluation: a task is ready when the iteration is running, the
// task has not started, and every edge enabled on the current path has a
// finished predecessor.
// Assumes: row i of each mask (bits i*N_TASK +: N_TASK) lists the predecessors of task i.
module tsch_ready #(
    parameter int                       N_TASK   = 6,
    parameter logic [N_TASK*N_TASK-1:0] PRED_ALL = '0,
    parameter logic [N_TASK*N_TASK-1:0] PRED_C1  = '0,
    parameter logic [N_TASK*N_TASK-1:0] PRED_C0  = '0
) (
    input  logic              run,
    input  logic              cond,
    input  logic [N_TASK-1:0] started,
    input  logic [N_TASK-1:0] finished,
    output logic [N_TASK-1:0] ready
);

    for (genvar i = 0; i < N_TASK; i++) begin : g_task
        logic [N_TASK-1:0] en_pred;
        // Merge the always-on edges with those of the current path, then test them.
        always_comb begin
            en_pred  = PRED_ALL[i*N_TASK +: N_TASK]
                     | (cond ? PRED_C1[i*N_TASK +: N_TASK] : PRED_C0[i*N_TASK +: N_TASK]);
            ready[i] = run && !started[i] && ((en_pred & ~finished) == '0);
        end
    end

endmodule

// File: rtl/tsch_swarb.sv
// Static-priority picker for software tasks: the lowest rank wins, and a tie
// goes to the lower index.
// Assumes: cand only contains software tasks.
module tsch_swarb #(
    parameter int                       N_TASK  = 6,
    parameter int                       RANK_W  = 3,
    parameter logic [N_TASK*RANK_W-1:0] SW_RANK = '0,
    localparam int                      IDX_W   = $clog2(N_TASK)
) (
    input  logic [N_TASK-1:0] cand,
    output logic              pick_vld,
    output logic [IDX_W-1:0]  pick_idx,
    output logic [N_TASK-1:0] pick_oh
);

    logic [RANK_W-1:0] best_rank;

    // Linear scan keeping the best rank seen so far (strict < keeps the lower index on a tie).
    always_comb begin
        pick_vld  = 1'b0;
        pick_idx  = '0;
        pick_oh   = '0;
        best_rank = '1;
        for (int i = 0; i < N_TASK; i++) begin
            if (cand[i] && (!pick_vld || SW_RANK[i*RANK_W +: RANK_W] < best_rank)) begin
                pick_vld  = 1'b1;
                pick_idx  = IDX_W'(i);
                best_rank = SW_RANK[i*RANK_W +: RANK_W];
                pick_oh   = '0;
                pick_oh[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tsch_top.sv
// Hardware run-time task scheduler. It walks one iteration of a parameterised
// task graph. Hardware tasks get one-cycle start strobes. Software tasks are
// sent one at a time to a single CPU through an interrupt request carrying a
// task index.
// Assumes: every task answers each start with exactly one done pulse, and the
// CPU runs each software task to completion.
module tsch_top #(
    parameter int                       N_TASK    = 6,
    parameter int                       RANK_W    = 3,
    parameter logic [N_TASK-1:0]        SW_MASK   = 6'b010101,
    parameter logic [N_TASK*N_TASK-1:0] PRED_ALL  = {6'b000000, 6'b000010, 6'b000000,
                                                     6'b000010, 6'b000000, 6'b000000},
    parameter logic [N_TASK*N_TASK-1:0] PRED_C1   = {6'b000000, 6'b000000, 6'b000001,
                                                     6'b000000, 6'b000000, 6'b000000},
    parameter logic [N_TASK*N_TASK-1:0] PRED_C0   = {6'b010000, 6'b000100, 6'b000100,
                                                     6'b000000, 6'b000000, 6'b000000},
    parameter logic [N_TASK*RANK_W-1:0] SW_RANK   = {3'd7, 3'd1, 3'd7, 3'd2, 3'd7, 3'd0},
    parameter logic [N_TASK-1:0]        SINK_PRED = '1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      go,
    input  logic                      cond_in,
    input  logic [N_TASK-1:0]         done_in,
    output logic [N_TASK-1:0]         hw_start,
    output logic                      sw_irq,
    output logic [$clog2(N_TASK)-1:0] sw_idx,
    output logic                      busy,
    output logic                      complete,
    output logic                      err
);

    localparam int                IDX_W   = $clog2(N_TASK);
    localparam logic [N_TASK-1:0] HW_MASK = ~SW_MASK;

    logic              run;
    logic              cond_q;
    logic [N_TASK-1:0] started_q;
    logic [N_TASK-1:0] finished_q;
    logic [N_TASK-1:0] ready;
    logic [N_TASK-1:0] cand;
    logic              pick_vld;
    logic [IDX_W-1:0]  pick_idx;
    logic [N_TASK-1:0] pick_oh;
    logic [N_TASK-1:0] sw_sel_q;
    logic              dispatch;
    logic              sw_done_hit;
    logic [N_TASK-1:0] launch;

    tsch_iter #(
        .N_TASK    (N_TASK),
        .SINK_PRED (SINK_PRED)
    ) u_iter (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .cond_in    (cond_in),
        .launch     (launch),
        .done_in    (done_in),
        .run        (run),
        .cond_q     (cond_q),
        .started_q  (started_q),
        .finished_q (finished_q),
        .complete   (complete),
        .err        (err)
    );

    tsch_ready #(
        .N_TASK   (N_TASK),
        .PRED_ALL (PRED_ALL),
        .PRED_C1  (PRED_C1),
        .PRED_C0  (PRED_C0)
    ) u_ready (
        .run      (run),
        .cond     (cond_q),
        .started  (started_q),
        .finished (finished_q),
        .ready    (ready)
    );

    tsch_swarb #(
        .N_TASK  (N_TASK),
        .RANK_W  (RANK_W),
        .SW_RANK (SW_RANK)
    ) u_swarb (
        .cand     (cand),
        .pick_vld (pick_vld),
        .pick_idx (pick_idx),
        .pick_oh  (pick_oh)
    );

    // Decide this cycle's launches: all ready hardware tasks, plus one software task if the CPU is free.
    always_comb begin
        cand        = ready & SW_MASK;
        dispatch    = pick_vld && !sw_irq;
        sw_done_hit = sw_irq && ((done_in & sw_sel_q) != '0);
        launch      = (ready & HW_MASK) | (dispatch ? pick_oh : '0);
    end

    // Output registers: hardware start strobes and the software interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw_start <= '0;
            sw_irq   <= 1'b0;
            sw_idx   <= '0;
            sw_sel_q <= '0;
        end else begin
            hw_start <= ready & HW_MASK;
            if (dispatch) begin
                sw_irq   <= 1'b1;
                sw_idx   <= pick_idx;
                sw_sel_q <= pick_oh;
            end else if (sw_done_hit) begin
                sw_irq   <= 1'b0;
                sw_sel_q <= '0;
            end
        end
    end

    assign busy = run;

    // R6: the request and its index hold until the dispatched task reports done.
    a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_irq && !sw_done_hit) |=> (sw_irq && $stable(sw_idx)));

    // R6: once the dispatched task reports done, the request is low for a cycle.
    a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n)
        sw_done_hit |=> !sw_irq);

    // R3: a start strobe never lasts two cycles.
    a_r3_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_start & $past(hw_start)) == '0);

    // R5: a software task is never dispatched again once it has been started.
    a_r5_sw_once: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch |-> ((pick_oh & started_q) == '0));

endmodule

// File: tb/sim_tsch_top.sv
// Directed bench for tsch_top. A responder answers every start with a done
// pulse three cycles later and records the order of software dispatches.
module sim_tsch_top;

    localparam int              N   = 6;
    localparam int              LAT = 3;
    localparam logic [N-1:0]    SWM = 6'b010101;

    logic         clk;
    logic         rst_n;
    logic         go;
    logic         cond_in;
    logic [N-1:0] done_in;
    logic [N-1:0] resp_done;
    logic [N-1:0] man_done;
    logic [N-1:0] hw_start;
    logic         sw_irq;
    logic [2:0]   sw_idx;
    logic         busy;
    logic         complete;
    logic         err;

    int n_chk  = 0;
    int n_fail = 0;
    int cnt     [N];
    int hw_cnt  [N];
    int sw_log  [8];
    int sw_n;
    logic irq_prev;

    assign done_in = resp_done | man_done;

    tsch_top u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .cond_in  (cond_in),
        .done_in  (done_in),
        .hw_start (hw_start),
        .sw_irq   (sw_irq),
        .sw_idx   (sw_idx),
        .busy     (busy),
        .complete (complete),
        .err      (err)
    );

    // 50 MHz clock
    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Responder: answers strobes and requests, and logs the software order.
    initial begin
        resp_done = '0;
        irq_prev  = 1'b0;
        sw_n      = 0;
        for (int i = 0; i < N; i++) begin cnt[i] = 0; hw_cnt[i] = 0; end
        forever begin
            @(negedge clk);
            resp_done = '0;
            if (rst_n) begin
                for (int i = 0; i < N; i++) begin
                    if (cnt[i] == 1) resp_done[i] = 1'b1;
                    if (cnt[i] > 0) cnt[i]--;
                end
                for (int i = 0; i < N; i++) begin
                    if (hw_start[i]) begin cnt[i] = LAT; hw_cnt[i]++; end
                end
                if (sw_irq && !irq_prev) begin
                    cnt[sw_idx] = LAT;
                    if (sw_n < 8) sw_log[sw_n] = int'(sw_idx);
                    sw_n++;
                end
            end
            irq_prev = sw_irq;
        end
    end

    task automatic clear_log();
        for (int i = 0; i < N; i++) hw_cnt[i] = 0;
        sw_n = 0;
    endtask

    task automatic pulse_go(input logic c);
        @(negedge clk);
        go = 1'b1; cond_in = c;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_complete(input string req);
        int k;
        k = 0;
        while (!complete && k < 500) begin @(negedge clk); k++; end
        chk(req, "complete rises", int'(complete), 1);
    endtask

    task automatic check_run(input string req, input int a, input int b, input int c);
        chk(req, "sw dispatch count", sw_n, 3);
        chk(req, "sw order 1st", sw_log[0], a);
        chk(req, "sw order 2nd", sw_log[1], b);
        chk(req, "sw order 3rd", sw_log[2], c);
        for (int i = 0; i < N; i++) begin
            if (!SWM[i]) chk("R5", "hw start count", hw_cnt[i], 1);
        end
        chk("R8", "busy low at end", int'(busy), 0);
    endtask

    // R1: reset values at the ports.
    task automatic t_reset();
        rst_n = 1'b0; go = 1'b0; cond_in = 1'b0; man_done = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "complete", int'(complete), 0);
        chk("R1", "err", int'(err), 0);
        chk("R1", "sw_irq", int'(sw_irq), 0);
        chk("R1", "hw_start", int'(hw_start), 0);
    endtask

    // R2/R3/R4/R6/R7/R8: cond=1 path, exact first-cycle timing, priority order 0,4,2.
    task automatic t_path_c1();
        clear_log();
        pulse_go(1'b1);
        chk("R2", "busy after go", int'(busy), 1);
        @(negedge clk);
        chk("R3", "first strobes", int'(hw_start), 6'b100010);
        chk("R6", "first irq", int'(sw_irq), 1);
        chk("R7", "first index", int'(sw_idx), 0);
        @(negedge clk);
        chk("R3", "strobe is one cycle", int'(hw_start), 0);
        chk("R6", "irq held", int'(sw_irq), 1);
        chk("R6", "index held", int'(sw_idx), 0);
        wait_complete("R8");
        check_run("R7", 0, 4, 2);
        chk("R9", "no err", int'(err), 0);
        repeat (3) @(negedge clk);
        chk("R8", "complete held", int'(complete), 1);
    endtask

    // R4/R2: cond=0 path forces 0,2,4; a go with cond_in=1 mid-run is ignored.
    task automatic t_path_c0_busy_go();
        clear_log();
        pulse_go(1'b0);
        repeat (4) @(negedge clk);
        go = 1'b1; cond_in = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk("R2", "busy kept", int'(busy), 1);
        wait_complete("R4");
        check_run("R4", 0, 2, 4);
    endtask

    // R9: stray done in idle and during a run.
    task automatic t_stray();
        @(negedge clk);
        man_done = 6'b001000;
        @(negedge clk);
        man_done = '0;
        chk("R9", "err after idle stray", int'(err), 1);
        clear_log();
        pulse_go(1'b0);
        chk("R9", "err cleared by go", int'(err), 0);
        man_done = 6'b001000;
        @(negedge clk);
        man_done = '0;
        chk("R9", "err after run stray", int'(err), 1);
        chk("R9", "no early complete", int'(complete), 0);
        wait_complete("R9");
        chk("R9", "task 3 still started once", hw_cnt[3], 1);
        check_run("R9", 0, 2, 4);
        chk("R9", "err sticky", int'(err), 1);
    endtask

    // Watchdog: counts as a failed check and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_path_c1();
        t_path_c0_busy_go();
        t_stray();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule